// File: doc/BRIEF.md
# Converter Clock Control and Rate Timer

This block sits in the digital back end of a sigma-delta converter. It holds the byte-wide clock-control setting, written and read over a plain parallel register port. From that setting it decides three things. The first is whether the master clock is used as it is or halved to form the internal clock. The second is whether the clock-output pin carries the master clock or is held low. The third is how often a new output word becomes ready. The word rate comes from a clock-range bit and a two-bit filter code, and selects one of eight non-uniform rates.

The block marks each output word with a single-cycle data-ready strobe. A period counter, advanced by internal-clock ticks, produces that strobe. When an oscillator circuit drives the master clock, gating the output pin stops the internal clock, so the strobe stops too. An accepted write that alters the clock-range bit or the filter code restarts the period counter. The same write raises a sticky recalibration request, which stays set until it is acknowledged. A write that puts a one into any reserved bit is rejected and reported as a configuration error.

Top module: `cvt_clk_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, reg_rdata_o reads 0x05, and drdy_o, recal_req_o and cfg_err_o are low.
- R2: A write with any of bits 7..5 set leaves reg_rdata_o unchanged. cfg_err_o is high for exactly the one cycle after the write edge.
- R3: A write with bits 7..5 all zero is stored and read back on reg_rdata_o from the next cycle. The field layout is: bit 4 output gate, bit 3 divide-by-two, bit 2 clock range, bits 1..0 filter code.
- R4: With bit 4 clear, mclk_out_o follows clk_i, being high in the high phase and low in the low phase. With bit 4 set, mclk_out_o is low in both phases.
- R5: With bit 3 set, the internal clock ticks on every second master cycle, so the data-ready interval in master cycles is twice the tick count of R6.
- R6: The data-ready period, in internal ticks, is F / (rate x RATE_DIV), truncated. F is CLK_HI_HZ when bit 2 is 1 and CLK_LO_HZ when it is 0. With bit 2 = 0, filter codes 0..3 give rates 20, 25, 100 and 200. With bit 2 = 1, they give 50, 60, 250 and 500.
- R7: drdy_o is a pulse one master cycle wide. With the setting unchanged, successive pulses are spaced by exactly one period.
- R8: While osc_mode_i is 1 and bit 4 is set, the internal clock is stopped and drdy_o stays low. With osc_mode_i at 0, bit 4 does not stop the strobe.
- R9: An accepted write whose bits 2..0 differ from the stored ones sets recal_req_o from the next cycle and restarts the counter. Without divide-by-two, the first drdy_o after the write edge then comes exactly one period later. An accepted write that keeps bits 2..0 leaves recal_req_o as it was.
- R10: recal_req_o stays set until recal_ack_i is high at an edge, and then clears. If the ack arrives at the same edge as a write that sets the flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| osc_mode_i | input | 1 | 1 when an oscillator circuit drives the master clock |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Current register contents |
| recal_ack_i | input | 1 | Clears the recalibration request |
| mclk_out_o | output | 1 | Gated master clock output |
| drdy_o | output | 1 | One-cycle data-ready strobe |
| recal_req_o | output | 1 | Sticky recalibration request |
| cfg_err_o | output | 1 | One-cycle illegal-configuration flag |

## Verification
The pulse-width property assumes that every entry of the period table is at least two ticks. Without that, back-to-back strobes would be correct behaviour. The bench keeps within this by scaling the rates with RATE_DIV = 1000, which makes the shortest period four ticks. The stop property assumes that osc_mode_i and the gate bit have both held for a cycle before the strobe is judged. The bench therefore changes osc_mode_i only at falling edges and leaves a few cycles to settle before it counts strobes. The output-pin gating cannot be observed at a rising edge, so the bench checks it directly in each clock phase.

// File: rtl/cvt_clk_pkg.sv
// Package: shared types and the rate-period computation for the converter
// clock control block. Assumes callers pass nonzero clock and divisor values.
package cvt_clk_pkg;

    typedef struct packed {
        logic [2:0] rsv;      // must stay zero
        logic       clk_dis;  // gate the clock output pin
        logic       clk_div;  // halve the master clock
        logic       clk_hi;   // clock range select
        logic [1:0] fsel;     // filter code
    } cvt_cfg_t;

    localparam cvt_cfg_t CFG_RESET = 8'h05;

    // Word rate in words per second for a 3-bit rate code {clk_hi, fsel}
    function automatic int unsigned code_rate(input logic [2:0] code);
        case (code)
            3'd0:    return 20;
            3'd1:    return 25;
            3'd2:    return 100;
            3'd3:    return 200;
            3'd4:    return 50;
            3'd5:    return 60;
            3'd6:    return 250;
            default: return 500;
        endcase
    endfunction

    // Period in internal ticks for a code, never below one tick
    function automatic int unsigned rate_period(input logic [2:0] code,
                                                input int unsigned hi_hz,
                                                input int unsigned lo_hz,
                                                input int unsigned div);
        int unsigned f;
        int unsigned p;
        f = code[2] ? hi_hz : lo_hz;
        p = f / (code_rate(code) * div);
        return (p == 0) ? 1 : p;
    endfunction

endpackage

// File: rtl/cvt_cfg_reg.sv
// Module: clock-control register with the reserved-bit check and the sticky
// recalibration request. Assumes writes are single-cycle strobes.
module cvt_cfg_reg
    import cvt_clk_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     wr_i,
    input  cvt_cfg_t wdata_i,
    input  logic     ack_i,
    output cvt_cfg_t cfg_o,
    output logic     rate_chg_o,
    output logic     recal_o,
    output logic     err_o
);
    cvt_cfg_t cfg_q;
    logic     recal_q;
    logic     err_q;
    logic     legal;

    // Decode whether the write is accepted and whether it touches the rate bits
    always_comb begin
        legal      = wr_i && (wdata_i.rsv == 3'b000);
        rate_chg_o = legal && ({wdata_i.clk_hi, wdata_i.fsel} != {cfg_q.clk_hi, cfg_q.fsel});
    end

    // Store accepted writes and flag rejected ones for one cycle
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= CFG_RESET;
            err_q <= 1'b0;
        end else begin
            err_q <= wr_i && (wdata_i.rsv != 3'b000);
            if (legal) cfg_q <= wdata_i;
        end
    end

    // Sticky recalibration request, with a set winning over an acknowledge
    always_ff @(posedge clk_i) begin
        if (!rst_ni)         recal_q <= 1'b0;
        else if (rate_chg_o) recal_q <= 1'b1;
        else if (ack_i)      recal_q <= 1'b0;
    end

    assign cfg_o   = cfg_q;
    assign recal_o = recal_q;
    assign err_o   = err_q;
endmodule

// File: rtl/cvt_clk_gen.sv
// Module: forms the internal clock as an enable tick on the master clock,
// optionally halved, and gates the clock output pin. Assumes that in
// oscillator mode a gated pin stops the internal clock.
module cvt_clk_gen (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic osc_mode_i,
    input  logic clk_dis_i,
    input  logic clk_div_i,
    output logic mclk_out_o,
    output logic tick_o
);
    logic ph_q;
    logic run;

    // Decide whether the internal clock runs and when it ticks
    always_comb begin
        run    = !(osc_mode_i && clk_dis_i);
        tick_o = run && (!clk_div_i || ph_q);
    end

    // Phase toggle used for the divide-by-two
    always_ff @(posedge clk_i) begin
        if (!rst_ni)  ph_q <= 1'b0;
        else if (run) ph_q <= ~ph_q;
    end

    assign mclk_out_o = clk_i & ~clk_dis_i;
endmodule

// File: rtl/cvt_rate_timer.sv
// Module: counts internal ticks and emits a one-master-cycle data-ready
// pulse once per selected period. Assumes every table period is at least 1.
module cvt_rate_timer
    import cvt_clk_pkg::*;
#(
    parameter int unsigned CLK_HI_HZ = 2457600,
    parameter int unsigned CLK_LO_HZ = 1000000,
    parameter int unsigned RATE_DIV  = 1,
    parameter int unsigned CNT_W     = 20,
    parameter int unsigned N_CODES   = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       restart_i,
    input  logic [2:0] code_i,
    output logic       drdy_o
);
    logic [CNT_W-1:0] per_tab [N_CODES];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             drdy_q;

    // One constant period entry per rate code
    for (genvar g = 0; g < N_CODES; g++) begin : g_per
        assign per_tab[g] = CNT_W'(rate_period(3'(g), CLK_HI_HZ, CLK_LO_HZ, RATE_DIV));
    end

    // Terminal count for the current code
    assign last = per_tab[code_i] - CNT_W'(1);

    // Advance the counter on ticks, restart on rate change, pulse at wrap
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            drdy_q <= 1'b0;
        end else begin
            drdy_q <= 1'b0;
            if (restart_i) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q >= last) begin
                    cnt_q  <= '0;
                    drdy_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign drdy_o = drdy_q;
endmodule

// File: rtl/cvt_clk_ctrl.sv
// Module: top of the converter clock control and rate timer. Ties the
// register, clock former and rate timer together. Assumes one master clock
// domain and a synchronous active-low reset.
module cvt_clk_ctrl
    import cvt_clk_pkg::*;
#(
    parameter int unsigned CLK_HI_HZ = 2457600,
    parameter int unsigned CLK_LO_HZ = 1000000,
    parameter int unsigned RATE_DIV  = 1,
    parameter int unsigned CNT_W     = 20
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       osc_mode_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic       recal_ack_i,
    output logic       mclk_out_o,
    output logic       drdy_o,
    output logic       recal_req_o,
    output logic       cfg_err_o
);
    cvt_cfg_t cfg;
    logic     rate_chg;
    logic     tick;

    cvt_cfg_reg u_reg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (reg_wr_i),
        .wdata_i    (cvt_cfg_t'(reg_wdata_i)),
        .ack_i      (recal_ack_i),
        .cfg_o      (cfg),
        .rate_chg_o (rate_chg),
        .recal_o    (recal_req_o),
        .err_o      (cfg_err_o)
    );

    cvt_clk_gen u_gen (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .osc_mode_i (osc_mode_i),
        .clk_dis_i  (cfg.clk_dis),
        .clk_div_i  (cfg.clk_div),
        .mclk_out_o (mclk_out_o),
        .tick_o     (tick)
    );

    cvt_rate_timer #(
        .CLK_HI_HZ (CLK_HI_HZ),
        .CLK_LO_HZ (CLK_LO_HZ),
        .RATE_DIV  (RATE_DIV),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .restart_i (rate_chg),
        .code_i    ({cfg.clk_hi, cfg.fsel}),
        .drdy_o    (drdy_o)
    );

    assign reg_rdata_o = cfg;
endmodule

// File: rtl/cvt_clk_ctrl_chk.sv
// Module: property checker for cvt_clk_ctrl, attached by bind. Assumes every
// period is at least two ticks and that inputs change away from rising edges.
module cvt_clk_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       osc_mode_i,
    input logic       reg_wr_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] reg_rdata_o,
    input logic       recal_ack_i,
    input logic       drdy_o,
    input logic       recal_req_o,
    input logic       cfg_err_o
);
    assert_drdy_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drdy_o |=> !drdy_o);

    assert_stop_no_drdy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (osc_mode_i && reg_rdata_o[4]) && $past(osc_mode_i && reg_rdata_o[4]) |-> !drdy_o);

    assert_illegal_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && (reg_wdata_i[7:5] != 3'b000)) |=> ($stable(reg_rdata_o) && cfg_err_o));

    assert_legal_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && (reg_wdata_i[7:5] == 3'b000)) |=> (reg_rdata_o == $past(reg_wdata_i)));

    assert_recal_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && (reg_wdata_i[7:5] == 3'b000) && (reg_wdata_i[2:0] != reg_rdata_o[2:0]))
        |=> recal_req_o);

    assert_recal_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (recal_req_o && !recal_ack_i) |=> recal_req_o);
endmodule

bind cvt_clk_ctrl cvt_clk_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .osc_mode_i  (osc_mode_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .recal_ack_i (recal_ack_i),
    .drdy_o      (drdy_o),
    .recal_req_o (recal_req_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/tb_cvt_clk_ctrl.sv
// Bench: walks a vector table of rate settings, then runs directed tests for
// reset, gating, stop, illegal writes and the recalibration handshake.
module tb_cvt_clk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_mode = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ack = 1'b0;
    logic       mclk_out;
    logic       drdy;
    logic       recal;
    logic       err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cvt_clk_ctrl #(.RATE_DIV(1000)) dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .osc_mode_i  (osc_mode),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .recal_ack_i (ack),
        .mclk_out_o  (mclk_out),
        .drdy_o      (drdy),
        .recal_req_o (recal),
        .cfg_err_o   (err)
    );

    // {write data, expected master cycles between strobes}
    localparam logic [15:0] VEC [10] = '{
        {8'h00, 8'd50}, {8'h01, 8'd40}, {8'h02, 8'd10}, {8'h03, 8'd5},
        {8'h04, 8'd49}, {8'h05, 8'd40}, {8'h06, 8'd9},  {8'h07, 8'd4},
        {8'h0A, 8'd20}, {8'h0F, 8'd8}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write one byte; the capturing edge is the one between the two falls
    task automatic reg_write(input logic [7:0] d, input logic with_ack);
        @(negedge clk);
        wr = 1'b1; wdata = d; ack = with_ack;
        @(posedge clk);
        #1;
        wr = 1'b0; ack = 1'b0;
    endtask

    // Sample after edges; return delay to first strobe, interval, width flag
    task automatic watch(input int lim, output int first, output int intv, output bit wide);
        int  pos [2];
        int  np;
        bit  prev;
        np = 0; prev = 1'b0; wide = 1'b0;
        pos[0] = -1; pos[1] = -1;
        for (int n = 1; n <= lim && np < 2; n++) begin
            @(posedge clk);
            #1;
            if (drdy && prev) wide = 1'b1;
            if (drdy) begin
                pos[np] = n;
                np++;
            end
            prev = drdy;
        end
        @(posedge clk);
        #1;
        if (drdy && prev) wide = 1'b1;
        first = pos[0];
        intv  = (np == 2) ? pos[1] - pos[0] : -1;
    endtask

    initial begin
        int first;
        int intv;
        bit wide;
        int seen;
        repeat (3) @(posedge clk);
        #1;
        chk(rdata == 8'h05, "R1 reset value", rdata, 8'h05);
        chk(!drdy && !recal && !err, "R1 outputs low in reset", {drdy, recal, err}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(rdata == 8'h05 && !drdy && !recal && !err, "R1 after release", rdata, 8'h05);

        for (int i = 0; i < 10; i++) begin
            logic [7:0] d;
            int         e;
            d = VEC[i][15:8];
            e = int'(VEC[i][7:0]);
            reg_write(d, 1'b0);
            chk(rdata == d, "R3 readback", rdata, d);
            chk(recal == 1'b1, "R9 recal set on rate change", recal, 1);
            watch(4 * e + 20, first, intv, wide);
            if (!d[3]) chk(first == e, "R9 restart first strobe", first, e);
            chk(intv == e, d[3] ? "R5 halved period" : "R6 rate period", intv, e);
            chk(!wide, "R7 one-cycle strobe", wide, 0);
            @(negedge clk);
            ack = 1'b1;
            @(posedge clk);
            #1;
            ack = 1'b0;
            chk(recal == 1'b0, "R10 ack clears", recal, 0);
        end

        // Output pin with the gate clear: follows the clock
        @(posedge clk); #1;
        chk(mclk_out == 1'b1, "R4 pin high phase", mclk_out, 1);
        @(negedge clk); #1;
        chk(mclk_out == 1'b0, "R4 pin low phase", mclk_out, 0);

        // Gate set with the same rate bits: no recal, pin held low
        reg_write(8'h1F, 1'b0);
        chk(recal == 1'b0, "R9 no recal when rate bits kept", recal, 0);
        @(posedge clk); #1;
        chk(mclk_out == 1'b0, "R4 gated pin high phase", mclk_out, 0);
        @(negedge clk); #1;
        chk(mclk_out == 1'b0, "R4 gated pin low phase", mclk_out, 0);

        // Without oscillator mode the strobe keeps running
        watch(60, first, intv, wide);
        chk(intv == 8, "R8 strobe continues without osc mode", intv, 8);

        // Oscillator mode with the gate set stops the strobe
        @(negedge clk);
        osc_mode = 1'b1;
        repeat (3) @(posedge clk);
        seen = 0;
        for (int n = 0; n < 100; n++) begin
            @(posedge clk); #1;
            if (drdy) seen++;
        end
        chk(seen == 0, "R8 stopped clock no strobe", seen, 0);
        @(negedge clk);
        osc_mode = 1'b0;
        watch(60, first, intv, wide);
        chk(intv == 8, "R8 strobe resumes", intv, 8);

        // Illegal write rejected and flagged for exactly one cycle
        reg_write(8'h85, 1'b0);
        chk(rdata == 8'h1F, "R2 register unchanged", rdata, 8'h1F);
        chk(err == 1'b1, "R2 error flagged", err, 1);
        @(posedge clk); #1;
        chk(err == 1'b0, "R2 error one cycle", err, 0);
        chk(recal == 1'b0, "R2 no recal from rejected write", recal, 0);

        // Set wins over a simultaneous ack, then a plain ack clears
        reg_write(8'h02, 1'b1);
        chk(recal == 1'b1, "R10 set wins over ack", recal, 1);
        @(posedge clk); #1;
        chk(recal == 1'b1, "R10 sticky", recal, 1);
        @(negedge clk);
        ack = 1'b1;
        @(posedge clk); #1;
        ack = 1'b0;
        chk(recal == 1'b0, "R10 ack clears later", recal, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule